// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block produces the two "almost" status flags of a synchronous FIFO. It watches the FIFO occupancy count supplied by the FIFO control logic and compares it against two 12-bit thresholds held in internal registers: a low-water offset that drives the almost-empty flag and a high-water offset that drives the almost-full flag. Both flags are active low, registered, and refreshed from the occupancy count on every clock.

The thresholds are written through the FIFO's ordinary write port. While the load strobe and the write enable are both low, each rising clock edge captures the low 12 data bits into one of the two offset registers. The target alternates, starting with the low-water register. During such load cycles the block tells the FIFO not to store the data word. A mode input selects between standard read timing and a fall-through timing in which the output register adds one word of capacity. In fall-through mode both thresholds move up by one word.

Top module: `afl_flag_unit`

## Requirements
- R1: While rst_n is low, almost_empty_n is 0, almost_full_n is 1, the low-water offset takes its default and the high-water offset takes its default, and the next load writes the low-water register. The default is 31 when DEPTH is 256, 63 when DEPTH is 512, and 127 otherwise.
- R2: store_wr is 1 only when wen_n is 0 and load_n is 1. No FIFO word is stored on an edge where load_n is 0.
- R3: On an edge with load_n = 0 and wen_n = 0, ofs_din is written into the register that the load sequence points at, and the pointer then toggles. The sequence is low-water, high-water, low-water, and so on.
- R4: An edge with load_n = 0 and wen_n = 1 writes no offset and keeps the pointer where it is.
- R5: An edge with load_n = 1 changes neither offset and points the load sequence back at the low-water register, so a new load run starts there.
- R6: With fwft_mode = 0, almost_empty_n one clock later is 1 exactly when occupancy > n, where n is the low-water offset.
- R7: With fwft_mode = 1, almost_empty_n one clock later is 1 exactly when occupancy > n + 1.
- R8: With fwft_mode = 0, almost_full_n one clock later is 0 exactly when occupancy ≥ DEPTH − m, where m is the high-water offset. If m > DEPTH, the flag is always 0.
- R9: With fwft_mode = 1, almost_full_n one clock later is 0 exactly when occupancy ≥ DEPTH + 1 − m.
- R10: Each flag is computed from the offset value held before the edge, so a new offset affects the flags from the second edge after it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the source |
| fwft_mode | input | 1 | 0 selects standard timing, 1 selects fall-through timing |
| load_n | input | 1 | Active-low offset load strobe |
| wen_n | input | 1 | Active-low FIFO write enable |
| ofs_din | input | OFS_W (12) | Low data bits, the offset value to load |
| occupancy | input | CNT_W = clog2(DEPTH+2) | Current FIFO word count, up to DEPTH+1 in fall-through mode |
| almost_empty_n | output | 1 | Registered almost-empty flag, active low |
| almost_full_n | output | 1 | Registered almost-full flag, active low |
| store_wr | output | 1 | Permits the FIFO to store the write data this cycle |

## Verification
The bench builds two copies side by side: one with DEPTH = 256 and one with DEPTH = 1024, both with 12-bit offsets. Together they cover the 31 and 127 reset defaults and two widths of occupancy count. With the smaller depth, a 12-bit offset can go well past the FIFO size, so the case where almost-full stays low for every occupancy can be reached. The occupancy is swept across every threshold in both modes, with default and loaded offsets, including offset 0. The load runs are broken up by write-enable gaps and by raising the load strobe.

// File: rtl/afl_pkg.sv
package afl_pkg;

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } ofs_sel_e;

  typedef enum logic {
    KIND_EMPTY = 1'b0,
    KIND_FULL  = 1'b1
  } flag_kind_e;

  // Reset-time threshold chosen from the FIFO depth.
  function automatic int default_offset(input int depth);
    if (depth == 256) begin
      return 31;
    end else if (depth == 512) begin
      return 63;
    end
    return 127;
  endfunction

endpackage

// File: rtl/afl_offset_bank.sv
module afl_offset_bank #(
  parameter int OFS_W   = 12,
  parameter int DEF_LOW = 31,
  parameter int DEF_HIGH = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             wen_n,
  input  logic [OFS_W-1:0] ofs_din,
  output logic [OFS_W-1:0] ofs_low,
  output logic [OFS_W-1:0] ofs_high
);
  import afl_pkg::*;

  localparam logic [OFS_W-1:0] RST_LOW  = OFS_W'(DEF_LOW);
  localparam logic [OFS_W-1:0] RST_HIGH = OFS_W'(DEF_HIGH);

  ofs_sel_e         sel_q, sel_d;
  logic [OFS_W-1:0] low_q, low_d;
  logic [OFS_W-1:0] high_q, high_d;
  logic             load_edge;

  assign load_edge = ~load_n & ~wen_n;

  always_comb begin
    sel_d  = sel_q;
    low_d  = low_q;
    high_d = high_q;
    if (load_n) begin
      sel_d = SEL_LOW;
    end else if (load_edge) begin
      if (sel_q == SEL_LOW) begin
        low_d = ofs_din;
        sel_d = SEL_HIGH;
      end else begin
        high_d = ofs_din;
        sel_d  = SEL_LOW;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_LOW;
      low_q  <= RST_LOW;
      high_q <= RST_HIGH;
    end else begin
      sel_q  <= sel_d;
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  assign ofs_low  = low_q;
  assign ofs_high = high_q;

endmodule

// File: rtl/afl_threshold.sv
module afl_threshold #(
  parameter int                  DEPTH = 256,
  parameter int                  CNT_W = 9,
  parameter int                  OFS_W = 12,
  parameter afl_pkg::flag_kind_e KIND  = afl_pkg::KIND_EMPTY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft,
  input  logic [CNT_W-1:0] occ,
  input  logic [OFS_W-1:0] ofs,
  output logic             flag_n
);
  import afl_pkg::*;

  localparam int CMP_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;
  localparam logic [CMP_W-1:0] DEPTH_X = CMP_W'(DEPTH);

  logic [CMP_W-1:0] occ_x, ofs_x, mode_x;
  logic             flag_d, flag_q;

  assign occ_x  = CMP_W'(occ);
  assign ofs_x  = CMP_W'(ofs);
  assign mode_x = CMP_W'(fwft);

  generate
    if (KIND == KIND_EMPTY) begin : g_low
      // High once the count exceeds the offset (plus one in fall-through).
      always_comb flag_d = (occ_x > (ofs_x + mode_x));
    end else begin : g_high
      // Low once count + offset reaches the depth (plus one in fall-through).
      always_comb flag_d = ~((occ_x + ofs_x) >= (DEPTH_X + mode_x));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= (KIND == KIND_FULL);
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_n = flag_q;

endmodule

// File: rtl/afl_flag_unit.sv
module afl_flag_unit #(
  parameter  int DEPTH = 256,
  parameter  int OFS_W = 12,
  localparam int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft_mode,
  input  logic             load_n,
  input  logic             wen_n,
  input  logic [OFS_W-1:0] ofs_din,
  input  logic [CNT_W-1:0] occupancy,
  output logic             almost_empty_n,
  output logic             almost_full_n,
  output logic             store_wr
);
  import afl_pkg::*;

  localparam int DEF_OFS = default_offset(DEPTH);

  logic [OFS_W-1:0] ofs_low_q;
  logic [OFS_W-1:0] ofs_high_q;

  afl_offset_bank #(
    .OFS_W    (OFS_W),
    .DEF_LOW  (DEF_OFS),
    .DEF_HIGH (DEF_OFS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .wen_n    (wen_n),
    .ofs_din  (ofs_din),
    .ofs_low  (ofs_low_q),
    .ofs_high (ofs_high_q)
  );

  afl_threshold #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .OFS_W (OFS_W),
    .KIND  (KIND_EMPTY)
  ) u_low_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .fwft   (fwft_mode),
    .occ    (occupancy),
    .ofs    (ofs_low_q),
    .flag_n (almost_empty_n)
  );

  afl_threshold #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .OFS_W (OFS_W),
    .KIND  (KIND_FULL)
  ) u_high_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .fwft   (fwft_mode),
    .occ    (occupancy),
    .ofs    (ofs_high_q),
    .flag_n (almost_full_n)
  );

  // Data words reach FIFO storage only outside load cycles.
  assign store_wr = ~wen_n & load_n;

endmodule

// File: rtl/afl_flag_checker.sv
module afl_flag_checker #(
  parameter int DEPTH = 256,
  parameter int OFS_W = 12,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fwft_mode,
  input logic             load_n,
  input logic             wen_n,
  input logic [CNT_W-1:0] occupancy,
  input logic [OFS_W-1:0] ofs_low,
  input logic [OFS_W-1:0] ofs_high,
  input logic             almost_empty_n,
  input logic             almost_full_n
);

  localparam int W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;

  logic [W-1:0] occ_w, low_w, high_w, dep_w;
  assign occ_w  = W'(occupancy);
  assign low_w  = W'(ofs_low);
  assign high_w = W'(ofs_high);
  assign dep_w  = W'(DEPTH);

  AST_IDLE_HOLDS_OFFSETS: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> ($stable(ofs_low) && $stable(ofs_high))); // R5

  AST_RUN_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !wen_n && $past(load_n)) |=> $stable(ofs_high)); // R3

  AST_PAUSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && wen_n) |=> ($stable(ofs_low) && $stable(ofs_high))); // R4

  AST_STD_LOW_WATER: assert property (@(posedge clk) disable iff (!rst_n)
    !fwft_mode |=> (almost_empty_n == ($past(occ_w) > $past(low_w)))); // R6

  AST_FWFT_LOW_WATER: assert property (@(posedge clk) disable iff (!rst_n)
    fwft_mode |=> (almost_empty_n == ($past(occ_w) > ($past(low_w) + 1'b1)))); // R7

  AST_STD_HIGH_WATER: assert property (@(posedge clk) disable iff (!rst_n)
    !fwft_mode |=> (almost_full_n == (($past(occ_w) + $past(high_w)) < dep_w))); // R8

  AST_FWFT_HIGH_WATER: assert property (@(posedge clk) disable iff (!rst_n)
    fwft_mode |=> (almost_full_n == (($past(occ_w) + $past(high_w)) < (dep_w + 1'b1)))); // R9

endmodule

bind afl_flag_unit afl_flag_checker #(
  .DEPTH (DEPTH),
  .OFS_W (OFS_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fwft_mode      (fwft_mode),
  .load_n         (load_n),
  .wen_n          (wen_n),
  .occupancy      (occupancy),
  .ofs_low        (ofs_low_q),
  .ofs_high       (ofs_high_q),
  .almost_empty_n (almost_empty_n),
  .almost_full_n  (almost_full_n)
);

// File: tb/tb_afl_flag_unit.sv
module tb_afl_flag_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DA = 256;
  localparam int DB = 1024;
  localparam int CWA = $clog2(DA + 2);
  localparam int CWB = $clog2(DB + 2);

  logic            clk;
  logic            rst_n;
  logic            fwft_mode;
  logic            load_n;
  logic            wen_n;
  logic [11:0]     ofs_din;
  logic [CWA-1:0]  occ_a;
  logic [CWB-1:0]  occ_b;
  logic            ae_a, af_a, st_a;
  logic            ae_b, af_b, st_b;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Reference model state, index 0 = DEPTH 256, index 1 = DEPTH 1024
  int depth[2];
  int n_ofs[2];
  int m_ofs[2];
  int ptr[2];
  bit exp_ae[2];
  bit exp_af[2];
  int occ_v[2];

  afl_flag_unit #(.DEPTH(DA), .OFS_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .load_n(load_n),
    .wen_n(wen_n), .ofs_din(ofs_din), .occupancy(occ_a),
    .almost_empty_n(ae_a), .almost_full_n(af_a), .store_wr(st_a)
  );

  afl_flag_unit #(.DEPTH(DB), .OFS_W(12)) dut_b (
    .clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .load_n(load_n),
    .wen_n(wen_n), .ofs_din(ofs_din), .occupancy(occ_b),
    .almost_empty_n(ae_b), .almost_full_n(af_b), .store_wr(st_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    depth[0] = DA; depth[1] = DB;
    n_ofs[0] = 31; m_ofs[0] = 31;   // R1 default for 256
    n_ofs[1] = 127; m_ofs[1] = 127; // R1 default for deeper
    for (int i = 0; i < 2; i++) begin
      ptr[i] = 0; exp_ae[i] = 1'b0; exp_af[i] = 1'b1;
    end
  endtask

  // One clock: inputs set at negedge, model advanced at posedge, outputs compared at next negedge.
  task automatic cycle(input int occ, input bit ld_n, input bit we_n, input int d, input string req);
    occ_v[0] = (occ > DA + 1) ? DA + 1 : occ;
    occ_v[1] = (occ > DB + 1) ? DB + 1 : occ;
    occ_a = CWA'(occ_v[0]);
    occ_b = CWB'(occ_v[1]);
    load_n = ld_n; wen_n = we_n; ofs_din = 12'(d);
    #1;
    chk("R2 store_wr", int'(st_a), int'(!we_n && ld_n));
    chk("R2 store_wr", int'(st_b), int'(!we_n && ld_n));
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      exp_ae[i] = fwft_mode ? (occ_v[i] > n_ofs[i] + 1) : (occ_v[i] > n_ofs[i]);
      exp_af[i] = !(occ_v[i] + m_ofs[i] >= depth[i] + int'(fwft_mode));
      if (ld_n) ptr[i] = 0;
      else if (!we_n) begin
        if (ptr[i] == 0) n_ofs[i] = d & 12'hfff; else m_ofs[i] = d & 12'hfff;
        ptr[i] = 1 - ptr[i];
      end
    end
    @(negedge clk);
    chk({req, " ae_a"}, int'(ae_a), int'(exp_ae[0]));
    chk({req, " af_a"}, int'(af_a), int'(exp_af[0]));
    chk({req, " ae_b"}, int'(ae_b), int'(exp_ae[1]));
    chk({req, " af_b"}, int'(af_b), int'(exp_af[1]));
  endtask

  task automatic sweep(input int lo, input int hi, input string req);
    for (int o = lo; o <= hi; o++) cycle(o, 1'b1, 1'b0, 0, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; fwft_mode = 1'b0; load_n = 1'b1; wen_n = 1'b1;
    ofs_din = '0; occ_a = '0; occ_b = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset ae", int'(ae_a), 0);
    chk("R1 reset af", int'(af_a), 1);
    chk("R1 reset ae_b", int'(ae_b), 0);
    chk("R1 reset af_b", int'(af_b), 1);
    rst_n = 1'b1;

    // R6/R8 with the reset defaults: cross both thresholds
    sweep(0, 40, "R6 R1 default low-water");
    sweep(120, 135, "R6 default low-water b");
    sweep(215, 257, "R8 R1 default high-water");
    sweep(890, 900, "R8 default high-water b");

    // R3: run of three loads, low, high, low
    cycle(10, 1'b0, 1'b0, 5, "R3 load low");
    cycle(10, 1'b0, 1'b0, 20, "R3 load high");
    cycle(10, 1'b0, 1'b0, 7, "R3 load low again");
    cycle(10, 1'b1, 1'b1, 0, "R10 idle");
    sweep(0, 12, "R6 loaded low-water");
    sweep(230, 257, "R8 loaded high-water");

    // R4: pause in a load run keeps the pointer; next write goes to high
    cycle(0, 1'b0, 1'b0, 3, "R3 load low");
    cycle(0, 1'b0, 1'b1, 99, "R4 pause");
    cycle(0, 1'b0, 1'b1, 98, "R4 pause");
    cycle(0, 1'b0, 1'b0, 40, "R4 load high after pause");
    cycle(0, 1'b1, 1'b1, 0, "R10 idle");
    sweep(0, 6, "R4 low-water 3");
    sweep(210, 220, "R4 high-water 40");

    // R5: raising load restarts the run at low
    cycle(0, 1'b0, 1'b0, 9, "R3 load low");
    cycle(0, 1'b1, 1'b0, 0, "R5 exit load");
    cycle(0, 1'b0, 1'b0, 2, "R5 restart at low");
    cycle(0, 1'b1, 1'b0, 0, "R5 exit load");
    sweep(0, 5, "R5 low-water 2");
    sweep(210, 220, "R5 high-water unchanged");

    // R10: flag uses old offset on the load edge
    cycle(6, 1'b0, 1'b0, 10, "R10 load low to 10");
    cycle(6, 1'b1, 1'b1, 0, "R10 new offset");

    // R7/R9 fall-through mode
    fwft_mode = 1'b1;
    sweep(0, 14, "R7 fwft low-water");
    sweep(120, 135, "R7 fwft low-water b");
    sweep(210, 257, "R9 fwft high-water");
    sweep(880, 900, "R9 fwft high-water b");

    // Offsets 0 and beyond the depth
    cycle(0, 1'b0, 1'b0, 0, "R3 load low 0");
    cycle(0, 1'b0, 1'b0, 300, "R3 load high 300");
    cycle(0, 1'b1, 1'b1, 0, "R10 idle");
    sweep(0, 4, "R7 zero offset");
    sweep(250, 257, "R9 high offset past depth");
    fwft_mode = 1'b0;
    sweep(0, 4, "R6 zero offset");
    sweep(0, 3, "R8 always low past depth");
    sweep(250, 257, "R8 always low past depth");

    // R1 again: reset restores defaults
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 re-reset ae", int'(ae_a), 0);
    chk("R1 re-reset af", int'(af_a), 1);
    rst_n = 1'b1;
    sweep(28, 34, "R1 defaults restored");
    sweep(224, 227, "R1 defaults restored");
    cycle(0, 1'b0, 1'b0, 1, "R1 pointer at low after reset");
    cycle(0, 1'b1, 1'b1, 0, "R1 idle");
    sweep(0, 3, "R1 low written first");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule